// File: doc/BRIEF.md
# Text Display Cursor and Start Offset Register File

This block is a small register file for a character display controller. Software reaches it through two byte-wide I/O ports: an even port that takes a register number (the index) and an odd port that reads or writes the register the index selects. Two base port pairs lead to the block and are decoded identically: 0x3B4/0x3B5 and 0x3D4/0x3D5. Bit 0 of the port address selects between the index port and the data port.

The block stores a 16-bit screen start offset, a 16-bit cursor location and a one-bit cursor-hide flag. It drives all three continuously to the display pipeline. The pipeline uses only the low 12 bits of the cursor location. Given the current scan line inside a 16-line character cell, the block also produces a cursor-draw qualifier. That qualifier is true on the two lines that form the underline cursor, and only while the cursor is not hidden. Register numbers with no storage behind them read as zero and ignore writes.

Top module: `crtc_cursor_regs`

## Requirements
- R1: An access hits the block only when portAddr[15:1] equals 0x3B4>>1 or 0x3D4>>1. The two pairs behave identically. Any other address changes no register and returns rdData = 0.
- R2: A write to the even port loads wrData into the 8-bit index. A read of the even port returns the current index.
- R3: A data write while the index is 0x0A sets cursorHidden to wrData bit 5. A data read at index 0x0A returns 0x20 when hidden and 0x00 otherwise.
- R4: Index 0x0C holds screen offset bits 15:8 and index 0x0D holds bits 7:0. screenOffset presents all 16 bits, and each byte reads back as written.
- R5: Index 0x0E holds cursor location bits 15:8 and index 0x0F holds bits 7:0. cursorPos presents bits 11:0, and each byte reads back in full as written.
- R6: At any index other than 0x0A, 0x0C, 0x0D, 0x0E or 0x0F, data reads return 0 and data writes change no output and no readable register. The whole 8-bit index is compared.
- R7: Data-port accesses, whether read or write, leave the index unchanged, so repeated data accesses reach the same register.
- R8: cursorDraw is 1 exactly when scanLine is 13 or 14 and cursorHidden is 0.
- R9: A synchronous reset (rst high at a clock edge) clears the index, the offset, the cursor location and the hide flag. After reset, screenOffset = 0, cursorPos = 0 and cursorHidden = 0.
- R10: rdData is 0 in every cycle that is not a read hitting the block (busSel low or busWr high). Reads are combinational within the access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busSel | input | 1 | I/O access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| portAddr | input | 16 | I/O port address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, 0 when not reading the block |
| scanLine | input | 4 | Current line inside the character cell |
| screenOffset | output | 16 | Screen start offset |
| cursorPos | output | 12 | Cursor character location |
| cursorHidden | output | 1 | Cursor-hide flag |
| cursorDraw | output | 1 | Cursor should be painted on this line |

## Verification
The properties assume that busSel is a single-cycle strobe and that busWr, portAddr and wrData are stable while it is high. They also assume that scanLine is a plain count within the 16-line cell. The stimulus makes every access one cycle long, with busSel dropped between accesses. It changes inputs one time unit after a rising edge and samples outputs on the falling edge, so no access overlaps the next. Decode is exercised with both base pairs, with neighbouring ports, and with an address that differs only in its upper bits. Index handling is exercised with an index that matches an implemented register only in its low nibble.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

  // strobes from decode to the register datapath
  typedef struct packed {
    logic idxWe;
    logic dataWe;
    logic idxRd;
    logic dataRd;
  } crtcStrobe_t;

  localparam logic [7:0] IDX_CURSOR_CTL = 8'h0A;
  localparam logic [7:0] IDX_START_HI   = 8'h0C;
  localparam logic [7:0] IDX_START_LO   = 8'h0D;
  localparam logic [7:0] IDX_CURSOR_HI  = 8'h0E;
  localparam logic [7:0] IDX_CURSOR_LO  = 8'h0F;

endpackage

// File: rtl/crtc_ctrl.sv
module crtc_ctrl
  import crtc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_MONO  = 16'h03B4,
  parameter logic [ADDR_W-1:0] BASE_COLOR = 16'h03D4
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] portAddr,
  output crtcStrobe_t       strobe
);

  localparam int NUM_BASE = 2;
  localparam logic [ADDR_W-1:0] BASES [NUM_BASE] = '{BASE_MONO, BASE_COLOR};

  logic [NUM_BASE-1:0] baseMatch;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BASE; gi++) begin : g_base
      assign baseMatch[gi] = (portAddr[ADDR_W-1:1] == BASES[gi][ADDR_W-1:1]);
    end
  endgenerate

  logic hit;
  logic isData;

  assign hit    = busSel && (|baseMatch);
  assign isData = portAddr[0];

  always_comb begin
    strobe        = '0;
    strobe.idxWe  = hit &&  busWr && !isData;
    strobe.dataWe = hit &&  busWr &&  isData;
    strobe.idxRd  = hit && !busWr && !isData;
    strobe.dataRd = hit && !busWr &&  isData;
  end

endmodule

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int POS_W     = 12,
  parameter int LINE_W    = 4,
  parameter int HIDE_BIT  = 5,
  parameter int CUR_FIRST = 13,
  parameter int CUR_LAST  = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  crtcStrobe_t           strobe,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [LINE_W-1:0]     scanLine,
  output logic [DATA_W-1:0]     rdData,
  output logic [DATA_W-1:0]     curIndex,
  output logic [2*DATA_W-1:0]   screenOffset,
  output logic [POS_W-1:0]      cursorPos,
  output logic                  cursorHidden,
  output logic                  cursorDraw
);

  localparam int WIDE_W = 2 * DATA_W;
  localparam logic [LINE_W-1:0] LINE_FIRST = LINE_W'(CUR_FIRST);
  localparam logic [LINE_W-1:0] LINE_LAST  = LINE_W'(CUR_LAST);

  logic [DATA_W-1:0] indexReg;
  logic [WIDE_W-1:0] startReg;
  logic [WIDE_W-1:0] cursorReg;
  logic              hideReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      indexReg  <= '0;
      startReg  <= '0;
      cursorReg <= '0;
      hideReg   <= 1'b0;
    end else begin
      if (strobe.idxWe) indexReg <= wrData;
      if (strobe.dataWe) begin
        case (indexReg)
          IDX_CURSOR_CTL: hideReg <= wrData[HIDE_BIT];
          IDX_START_HI:   startReg[WIDE_W-1:DATA_W]  <= wrData;
          IDX_START_LO:   startReg[DATA_W-1:0]       <= wrData;
          IDX_CURSOR_HI:  cursorReg[WIDE_W-1:DATA_W] <= wrData;
          IDX_CURSOR_LO:  cursorReg[DATA_W-1:0]      <= wrData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.idxRd) begin
      rdData = indexReg;
    end else if (strobe.dataRd) begin
      case (indexReg)
        IDX_CURSOR_CTL: rdData[HIDE_BIT] = hideReg;
        IDX_START_HI:   rdData = startReg[WIDE_W-1:DATA_W];
        IDX_START_LO:   rdData = startReg[DATA_W-1:0];
        IDX_CURSOR_HI:  rdData = cursorReg[WIDE_W-1:DATA_W];
        IDX_CURSOR_LO:  rdData = cursorReg[DATA_W-1:0];
        default:        rdData = '0;
      endcase
    end
  end

  assign curIndex     = indexReg;
  assign screenOffset = startReg;
  assign cursorPos    = cursorReg[POS_W-1:0];
  assign cursorHidden = hideReg;
  assign cursorDraw   = !hideReg && (scanLine >= LINE_FIRST) && (scanLine <= LINE_LAST);

endmodule

// File: rtl/crtc_cursor_regs.sv
module crtc_cursor_regs
  import crtc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int POS_W  = 12,
  parameter int LINE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   portAddr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [LINE_W-1:0]   scanLine,
  output logic [2*DATA_W-1:0] screenOffset,
  output logic [POS_W-1:0]    cursorPos,
  output logic                cursorHidden,
  output logic                cursorDraw
);

  crtcStrobe_t       strobe;
  logic [DATA_W-1:0] curIndex;

  crtc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .portAddr(portAddr),
    .strobe  (strobe)
  );

  crtc_regs #(.DATA_W(DATA_W), .POS_W(POS_W), .LINE_W(LINE_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .wrData      (wrData),
    .scanLine    (scanLine),
    .rdData      (rdData),
    .curIndex    (curIndex),
    .screenOffset(screenOffset),
    .cursorPos   (cursorPos),
    .cursorHidden(cursorHidden),
    .cursorDraw  (cursorDraw)
  );

endmodule

// File: rtl/crtc_cursor_regs_chk.sv
module crtc_cursor_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        busSel,
  input logic        busWr,
  input logic [15:0] portAddr,
  input logic [7:0]  wrData,
  input logic [7:0]  rdData,
  input logic [15:0] screenOffset,
  input logic [11:0] cursorPos,
  input logic        cursorHidden,
  input logic        cursorDraw,
  input logic [7:0]  curIndex
);

  logic anyHit;
  logic dataHit;
  logic knownIdx;

  assign anyHit   = (portAddr[15:1] == 15'h01DA) || (portAddr[15:1] == 15'h01EA);
  assign dataHit  = anyHit && portAddr[0];
  assign knownIdx = (curIndex == 8'h0A) || (curIndex == 8'h0C) || (curIndex == 8'h0D) ||
                    (curIndex == 8'h0E) || (curIndex == 8'h0F);

  // R4
  offset_hi_write_chk: assert property (@(posedge clk) disable iff (rst)
    (busSel && busWr && dataHit && curIndex == 8'h0C) |=> (screenOffset[15:8] == $past(wrData)));

  // R5
  cursor_lo_write_chk: assert property (@(posedge clk) disable iff (rst)
    (busSel && busWr && dataHit && curIndex == 8'h0F) |=> (cursorPos[7:0] == $past(wrData)));

  // R7
  index_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busSel && dataHit) |=> $stable(curIndex));

  // R1
  no_hit_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(busSel && anyHit) |=> ($stable(screenOffset) && $stable(cursorPos) &&
                             $stable(cursorHidden) && $stable(curIndex)));

  // R6
  unknown_idx_read_chk: assert property (@(posedge clk) disable iff (rst)
    (busSel && !busWr && dataHit && !knownIdx) |-> (rdData == 8'h00));

  // R8
  hidden_no_draw_chk: assert property (@(posedge clk) disable iff (rst)
    cursorHidden |-> !cursorDraw);

  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(busSel && !busWr && anyHit) |-> (rdData == 8'h00));

  // R3
  ctl_read_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (busSel && !busWr && dataHit && curIndex == 8'h0A) |-> ((rdData & 8'hDF) == 8'h00));

endmodule

bind crtc_cursor_regs crtc_cursor_regs_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .busSel      (busSel),
  .busWr       (busWr),
  .portAddr    (portAddr),
  .wrData      (wrData),
  .rdData      (rdData),
  .screenOffset(screenOffset),
  .cursorPos   (cursorPos),
  .cursorHidden(cursorHidden),
  .cursorDraw  (cursorDraw),
  .curIndex    (curIndex)
);

// File: tb/crtc_cursor_regs_tb.sv
`timescale 1ns / 1ps
module crtc_cursor_regs_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] portAddr = 16'h0000;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData;
  logic [3:0]  scanLine = 4'd0;
  logic [15:0] screenOffset;
  logic [11:0] cursorPos;
  logic        cursorHidden;
  logic        cursorDraw;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit readOn = 1'b0;

  logic [7:0] expQ [$];
  string      tagQ [$];

  always #2 clk = ~clk;

  crtc_cursor_regs u_dut (
    .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .portAddr(portAddr),
    .wrData(wrData), .rdData(rdData), .scanLine(scanLine), .screenOffset(screenOffset),
    .cursorPos(cursorPos), .cursorHidden(cursorHidden), .cursorDraw(cursorDraw)
  );

  // monitor: pops an expected read value and compares it with the port
  always @(negedge clk) begin
    if (readOn && expQ.size() > 0) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      total++;
      if (rdData !== e) begin
        bad++;
        $display("FAIL %s rdData actual=%h expected=%h", t, rdData, e);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    busSel = 1'b1; busWr = 1'b1; portAddr = a; wrData = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  // driver: starts a read and pushes its expected value
  task automatic busRead(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    busSel = 1'b1; busWr = 1'b0; portAddr = a;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    readOn = 1'b1;
    @(posedge clk); #1;
    busSel = 1'b0; readOn = 1'b0;
  endtask

  task automatic setReg(input logic [15:0] base, input logic [7:0] idx, input logic [7:0] d);
    busWrite(base, idx);
    busWrite(base | 16'h0001, d);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 offset", screenOffset, 32'h0);
    check("R9 cursorPos", cursorPos, 32'h0);
    check("R9 hidden", cursorHidden, 32'h0);
    busRead(16'h03D4, 8'h00, "R9 index");
    // R10 idle read port
    check("R10 idle rdData", rdData, 32'h0);

    // R4 offset through both port pairs (R1)
    setReg(16'h03D4, 8'h0C, 8'h12);
    setReg(16'h03B4, 8'h0D, 8'h34);
    check("R4 screenOffset", screenOffset, 32'h1234);
    busRead(16'h03D5, 8'h34, "R4 low byte readback");
    busRead(16'h03B4, 8'h0D, "R2 index readback");
    busWrite(16'h03B4, 8'h0C);
    busRead(16'h03D5, 8'h12, "R1 R4 high byte via other pair");

    // R5 cursor location
    setReg(16'h03D4, 8'h0E, 8'hAB);
    setReg(16'h03D4, 8'h0F, 8'hCD);
    check("R5 cursorPos low 12 bits", cursorPos, 32'hBCD);
    busWrite(16'h03D4, 8'h0E);
    busRead(16'h03D5, 8'hAB, "R5 high byte full readback");

    // R7 index held across data accesses
    busWrite(16'h03D4, 8'h0F);
    busWrite(16'h03D5, 8'h11);
    busWrite(16'h03D5, 8'h22);
    check("R7 repeated data write", cursorPos, 32'hB22);
    busRead(16'h03D5, 8'h22, "R7 data read after writes");
    busRead(16'h03D4, 8'h0F, "R7 index unchanged");

    // R3 hide flag
    setReg(16'h03D4, 8'h0A, 8'hFF);
    check("R3 hidden set", cursorHidden, 32'h1);
    busRead(16'h03D5, 8'h20, "R3 readback only bit5");
    // R8 hidden suppresses draw
    scanLine = 4'd13; #1;
    check("R8 hidden line13", cursorDraw, 32'h0);
    busWrite(16'h03D5, 8'hDF);
    check("R3 hidden cleared", cursorHidden, 32'h0);
    busRead(16'h03D5, 8'h00, "R3 readback clear");

    // R8 line window
    for (int ln = 0; ln < 16; ln++) begin
      scanLine = 4'(ln); #1;
      check("R8 draw window", cursorDraw, (ln == 13 || ln == 14) ? 32'h1 : 32'h0);
    end

    // R6 unimplemented indices
    setReg(16'h03D4, 8'h0B, 8'h55);
    busRead(16'h03D5, 8'h00, "R6 index 0B read");
    setReg(16'h03D4, 8'h1C, 8'h77);
    setReg(16'h03D4, 8'h8E, 8'h99);
    busWrite(16'h03D4, 8'h00);
    busRead(16'h03D5, 8'h00, "R6 index 00 read");
    check("R6 offset untouched", screenOffset, 32'h1234);
    check("R6 cursor untouched", cursorPos, 32'hB22);
    check("R6 hidden untouched", cursorHidden, 32'h0);
    busWrite(16'h03D4, 8'h0C);
    busRead(16'h03D5, 8'h12, "R6 high offset byte untouched");

    // R1 decode misses
    busWrite(16'h03C5, 8'hEE);
    busWrite(16'h13D5, 8'hEE);
    busWrite(16'h03D6, 8'h0D);
    check("R1 offset after misses", screenOffset, 32'h1234);
    busRead(16'h03C5, 8'h00, "R1 miss read");
    busRead(16'h03D4, 8'h0C, "R1 index after misses");

    // R10 write cycle keeps rdData at zero
    @(posedge clk); #1;
    busSel = 1'b1; busWr = 1'b1; portAddr = 16'h03D5; wrData = 8'h12;
    @(negedge clk);
    check("R10 rdData during write", rdData, 32'h0);
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;

    // R9 reset again mid-run
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    check("R9 offset after reset", screenOffset, 32'h0);
    check("R9 cursor after reset", cursorPos, 32'h0);
    scanLine = 4'd14; #1;
    check("R9 R8 visible after reset", cursorDraw, 32'h1);
    busRead(16'h03B4, 8'h00, "R9 index after reset");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule